// File: doc/BRIEF.md
# 8-bit Prescaled Up-Counter Timer

The block is an 8-bit up-counter with an overflow flag and an interrupt request. A 3-bit source selector picks what advances the counter: nothing, every system clock, one of four strobes taken from a free-running 10-bit prescale counter, or an edge seen on an external clock pin. The external pin is passed through a two-stage synchronizer and an edge detector, and it is never divided.

Software can write the count at any time. A common use is to write a reload value from the overflow handler, so the next overflow comes sooner and the interval can be tuned finely. The overflow flag is set when the counter wraps from 0xFF to 0x00. It is cleared when the interrupt is acknowledged or when software writes a 1 to it. The interrupt request is asserted while the flag, the local mask bit and the global enable are all high.

Top module: `tmr8_prescaled`

## Requirements
- R1: After a synchronous active-low reset, the count is 0x00, the selector is 000, and the flag, the mask and the interrupt request are all 0.
- R2: With selector 000 the count holds its value.
- R3: With selector 001 the count increases by one on every clock.
- R4: Selectors 010, 011, 100 and 101 advance the count exactly once in every 8, 64, 256 and 1024 clocks respectively.
- R5: Selector 111 advances the count once per rising edge of the external pin, and selector 110 once per falling edge. The edge of the opposite polarity has no effect, and no prescaling is applied. The pin may toggle no faster than once every 2 clocks.
- R6: When the count advances from 0xFF it becomes 0x00 and the overflow flag is set.
- R7: A count write loads the written value on the next clock edge. It takes priority over an advance in the same cycle and never sets the flag.
- R8: The interrupt request is high exactly when the flag, the mask bit and the global enable are all 1.
- R9: The flag is cleared by an acknowledge pulse or by a flag write with data 1. A flag write with data 0 has no effect, and an overflow in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_wr | input | 1 | Write strobe for the source selector |
| sel_wdata | input | 3 | New selector value |
| cnt_wr | input | 1 | Write strobe for the count |
| cnt_wdata | input | 8 | Value to load into the count |
| mask_wr | input | 1 | Write strobe for the interrupt mask bit |
| mask_wdata | input | 1 | New mask bit |
| flag_wr | input | 1 | Write strobe for the flag (write 1 to clear) |
| flag_wdata | input | 1 | 1 clears the flag, 0 has no effect |
| glob_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| ext_clk | input | 1 | External clock pin, asynchronous |
| cnt_q | output | 8 | Current count |
| sel_q | output | 3 | Current selector |
| mask_q | output | 1 | Current mask bit |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The count is first run from the undivided clock, starting from random reload values over random run lengths, so that runs that wrap can be told apart from runs that do not. Each prescaled selector is then timed over a window of whole divide periods. A wrong tap shows up as a wrong number of advances, whatever the prescaler phase. The external pin is toggled in trains of pulses under both edge selectors, with lone edges of the wrong polarity placed between trains, which shows whether each edge is counted once and only on the chosen polarity. Directed cases place a write and an overflow in the same cycle, and a clear and an overflow in the same cycle, to settle the priorities.

// File: rtl/tmr8_pkg.sv
// Shared types and constants for the prescaled 8-bit timer.
package tmr8_pkg;
    // Counter source selector; the binary value is the software-visible code.
    typedef enum logic [2:0] {
        SRC_OFF      = 3'b000,
        SRC_DIV1     = 3'b001,
        SRC_DIV8     = 3'b010,
        SRC_DIV64    = 3'b011,
        SRC_DIV256   = 3'b100,
        SRC_DIV1024  = 3'b101,
        SRC_EXT_FALL = 3'b110,
        SRC_EXT_RISE = 3'b111
    } src_sel_e;

    // log2 of each prescale divisor, i.e. the prescaler strobe index used.
    localparam int TAP_DIV8    = 3;
    localparam int TAP_DIV64   = 6;
    localparam int TAP_DIV256  = 8;
    localparam int TAP_DIV1024 = 10;
endpackage

// File: rtl/tmr8_prescaler.sv
// Free-running prescale counter. Strobe k is high for one clock in every
// 2**k clocks (strobe 0 is always high). Assumes PRE_W >= 1.
module tmr8_prescaler #(
    parameter int PRE_W = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [PRE_W:0] stb_o
);
    logic [PRE_W-1:0] pre_q;

    // Advance the shared prescale count on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // One strobe per power of two: all low bits at one marks the period end.
    for (genvar k = 0; k <= PRE_W; k++) begin : g_stb
        if (k == 0) begin : g_always
            assign stb_o[k] = 1'b1;
        end else begin : g_tap
            assign stb_o[k] = &pre_q[k-1:0];
        end
    end
endmodule

// File: rtl/tmr8_edge_sync.sv
// Brings an asynchronous pin into the clock domain through SYNC_STAGES
// flip-flops and flags its rising and falling edges for one clock each.
// Assumes the pin holds each level for at least two clocks.
module tmr8_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Synchronizer chain followed by one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Edge flags compare the synchronized level with its previous value.
    always_comb begin
        rise_o =  sync_q[SYNC_STAGES-1] & ~last_q;
        fall_o = ~sync_q[SYNC_STAGES-1] &  last_q;
    end
endmodule

// File: rtl/tmr8_count_core.sv
// Count register and overflow flag. Advances on tick_i, a software load
// has priority over the advance, a wrap sets the flag, and an acknowledge
// or a write of 1 clears it (a wrap in the same cycle wins).
module tmr8_count_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic wrap;

    // A wrap occurs only on a real advance from the top value without a load.
    always_comb wrap = tick_i && !load_i && (cnt_o == CNT_TOP);

    // Count register: load first, then advance.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_o <= '0;
        else if (load_i) cnt_o <= load_val_i;
        else if (tick_i) cnt_o <= cnt_o + 1'b1;
    end

    // Overflow flag: setting outranks clearing.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (wrap)  flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/tmr8_prescaled.sv
// Top of the 8-bit timer: holds the selector and mask registers, picks the
// advance strobe from the prescaler or the external edge detector, and
// forms the interrupt request. Assumes ext_clk toggles no faster than
// every two clocks.
module tmr8_prescaled
    import tmr8_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PRE_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic [2:0]       sel_wdata,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             mask_wr,
    input  logic             mask_wdata,
    input  logic             flag_wr,
    input  logic             flag_wdata,
    input  logic             glob_ie,
    input  logic             irq_ack,
    input  logic             ext_clk,
    output logic [CNT_W-1:0] cnt_q,
    output logic [2:0]       sel_q,
    output logic             mask_q,
    output logic             ovf_flag,
    output logic             irq
);
    logic [PRE_W:0] pre_stb;
    logic           ext_rise;
    logic           ext_fall;
    logic           tick;
    logic           clr;
    src_sel_e       sel;

    // Selector and mask registers written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= SRC_OFF;
            mask_q <= 1'b0;
        end else begin
            if (sel_wr)  sel_q  <= sel_wdata;
            if (mask_wr) mask_q <= mask_wdata;
        end
    end

    tmr8_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .stb_o (pre_stb)
    );

    tmr8_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_clk),
        .rise_o (ext_rise),
        .fall_o (ext_fall)
    );

    // Source multiplexer: choose the strobe that advances the counter.
    always_comb begin
        sel = src_sel_e'(sel_q);
        unique case (sel)
            SRC_OFF:      tick = 1'b0;
            SRC_DIV1:     tick = pre_stb[0];
            SRC_DIV8:     tick = pre_stb[TAP_DIV8];
            SRC_DIV64:    tick = pre_stb[TAP_DIV64];
            SRC_DIV256:   tick = pre_stb[TAP_DIV256];
            SRC_DIV1024:  tick = pre_stb[TAP_DIV1024];
            SRC_EXT_FALL: tick = ext_fall;
            SRC_EXT_RISE: tick = ext_rise;
            default:      tick = 1'b0;
        endcase
    end

    // Flag clear request: acknowledge or write-one.
    always_comb clr = irq_ack || (flag_wr && flag_wdata);

    tmr8_count_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (cnt_wr),
        .load_val_i (cnt_wdata),
        .clr_i      (clr),
        .cnt_o      (cnt_q),
        .flag_o     (ovf_flag)
    );

    // Interrupt request gated by local mask and global enable.
    always_comb irq = ovf_flag && mask_q && glob_ie;
endmodule

// File: rtl/tmr8_checker.sv
// Property checks for tmr8_prescaled, attached by bind.
module tmr8_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       sel_q,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic [CNT_W-1:0] cnt_q,
    input logic             ovf_flag,
    input logic             irq,
    input logic             irq_ack
);
    // R2
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 3'b000 && !cnt_wr) |=> $stable(cnt_q));

    // R3
    div1_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 3'b001 && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R6
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 3'b001 && !cnt_wr && cnt_q == '1) |=> (ovf_flag && cnt_q == '0));

    // R7
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(cnt_wdata)));

    // R7
    load_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !ovf_flag) |=> !ovf_flag);

    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovf_flag);

    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && cnt_q != '1) |=> !ovf_flag);
endmodule

bind tmr8_prescaled tmr8_checker #(.CNT_W(CNT_W)) u_tmr8_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_q     (sel_q),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .cnt_q     (cnt_q),
    .ovf_flag  (ovf_flag),
    .irq       (irq),
    .irq_ack   (irq_ack)
);

// File: tb/test_tmr8_prescaled.sv
// Self-checking bench for tmr8_prescaled.
module test_tmr8_prescaled;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel_wr = 0;
    logic [2:0] sel_wdata = 0;
    logic       cnt_wr = 0;
    logic [7:0] cnt_wdata = 0;
    logic       mask_wr = 0;
    logic       mask_wdata = 0;
    logic       flag_wr = 0;
    logic       flag_wdata = 0;
    logic       glob_ie = 0;
    logic       irq_ack = 0;
    logic       ext_clk = 0;
    logic [7:0] cnt_q;
    logic [2:0] sel_q;
    logic       mask_q;
    logic       ovf_flag;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tmr8_prescaled i_tmr8_prescaled (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .glob_ie(glob_ie), .irq_ack(irq_ack), .ext_clk(ext_clk),
        .cnt_q(cnt_q), .sel_q(sel_q), .mask_q(mask_q), .ovf_flag(ovf_flag),
        .irq(irq)
    );

    function automatic logic [7:0] exp_count(int start, int adv);
        return 8'((start + adv) % 256);
    endfunction

    function automatic logic exp_wrap(int start, int adv);
        return (start + adv) >= 256;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_sel(logic [2:0] v);
        sel_wr = 1; sel_wdata = v; step(1); sel_wr = 0;
    endtask

    // Load the count and clear the flag in the same cycle.
    task automatic load_clear(logic [7:0] v);
        cnt_wr = 1; cnt_wdata = v; flag_wr = 1; flag_wdata = 1;
        step(1);
        cnt_wr = 0; flag_wr = 0; flag_wdata = 0;
    endtask

    task automatic ext_pulses(int n);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1; step(4); ext_clk = 0; step(4);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_val;
        seed_val = $urandom(32'h5EED_7301);
        rst_n = 0;
        step(3);
        // R1 reset values
        check("R1 cnt", cnt_q, 0);
        check("R1 sel", sel_q, 0);
        check("R1 flag", ovf_flag, 0);
        check("R1 mask", mask_q, 0);
        check("R1 irq", irq, 0);
        rst_n = 1;
        step(1);

        // R2 stopped counter holds a loaded value
        load_clear(8'h5A);
        step(50);
        check("R2 hold", cnt_q, 8'h5A);

        // R3 / R6 random reloads under the undivided clock
        set_sel(3'b001);
        for (int it = 0; it < 40; it++) begin
            int v, n;
            v = int'($urandom_range(0, 255));
            n = int'($urandom_range(1, 300));
            load_clear(8'(v));
            step(n);
            check("R3 count", cnt_q, exp_count(v, n));
            check("R6 flag", ovf_flag, exp_wrap(v, n));
        end

        // R7 load wins over an advance from 0xFF and sets no flag
        load_clear(8'hFF);
        cnt_wr = 1; cnt_wdata = 8'hFF; step(1); cnt_wr = 0;
        check("R7 load value", cnt_q, 8'hFF);
        check("R7 no flag", ovf_flag, 0);
        step(1);
        check("R6 wrap to zero", cnt_q, 0);
        check("R6 wrap flag", ovf_flag, 1);

        // R9 a write of 0 keeps the flag; a write of 1 clears it
        flag_wr = 1; flag_wdata = 0; step(1); flag_wr = 0;
        check("R9 write0 keeps", ovf_flag, 1);
        flag_wr = 1; flag_wdata = 1; step(1); flag_wr = 0; flag_wdata = 0;
        check("R9 write1 clears", ovf_flag, 0);

        // R9 a wrap in the same cycle as a clear leaves the flag set
        load_clear(8'hFE);
        step(1);
        check("R9 setup", cnt_q, 8'hFF);
        irq_ack = 1; flag_wr = 1; flag_wdata = 1; step(1);
        irq_ack = 0; flag_wr = 0; flag_wdata = 0;
        check("R9 set wins", ovf_flag, 1);

        // R8 interrupt gating over all mask / enable pairs (flag is set)
        set_sel(3'b000);
        for (int m = 0; m < 2; m++) begin
            for (int g = 0; g < 2; g++) begin
                mask_wr = 1; mask_wdata = m[0]; glob_ie = g[0]; step(1); mask_wr = 0;
                check("R8 irq", irq, m & g);
            end
        end
        irq_ack = 1; step(1); irq_ack = 0;
        check("R9 ack clears", ovf_flag, 0);
        check("R8 irq low", irq, 0);
        glob_ie = 0;

        // R4 each prescaled selector over whole divide periods
        for (int it = 0; it < 8; it++) begin
            int code, div, k;
            code = 2 + (it % 4);
            div  = (code == 2) ? 8 : (code == 3) ? 64 : (code == 4) ? 256 : 1024;
            k    = int'($urandom_range(1, 3));
            set_sel(3'(code));
            step(int'($urandom_range(0, 20)));
            load_clear(8'h00);
            step(div * k);
            check("R4 prescaled", cnt_q, k);
        end

        // R5 external rising edges, lone falling edge ignored
        set_sel(3'b111);
        load_clear(8'h00);
        ext_pulses(5);
        step(6);
        check("R5 rising", cnt_q, 5);
        ext_clk = 1; step(8);
        check("R5 rise counts", cnt_q, 6);
        ext_clk = 0; step(8);
        check("R5 fall ignored", cnt_q, 6);

        // R5 external falling edges, lone rising edge ignored
        set_sel(3'b110);
        load_clear(8'h00);
        ext_pulses(7);
        step(6);
        check("R5 falling", cnt_q, 7);
        ext_clk = 1; step(8);
        check("R5 rise ignored", cnt_q, 7);
        ext_clk = 0; step(8);
        check("R5 fall counts", cnt_q, 8);

        // R5 fastest legal rate: a toggle every two clocks, no prescaling
        set_sel(3'b111);
        load_clear(8'h00);
        for (int i = 0; i < 20; i++) begin
            ext_clk = 1; step(2); ext_clk = 0; step(2);
        end
        step(6);
        check("R5 fast edges", cnt_q, 20);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule